// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Bank

The block holds four 16-bit counters that count upward on one shared system clock. Each channel has a control word and a reload word. A channel runs either from its own prescaler or, in chained mode, from the overflow pulses of the channel below it. Chaining lets two or more 16-bit channels act as one longer counter. When a counter wraps past its all-ones value, it reloads its stored reload word. It can also raise its own interrupt line, and it hands a count pulse to the channel above in the same clock.

Software reaches every channel through one write port and one read port. Each port carries a channel number and a selector for either the control word or the data word. A read of the data word returns the live count, not the reload word. The interrupt outputs go to an external interrupt controller. Line n belongs to channel n, and the system numbers that interrupt n+8.

Top module: `timer_bank`

## Requirements
- R1: Synchronous active-high reset sets every counter, reload word, control word and prescaler accumulator to zero, so every read returns 0 and `irq` is 0.
- R2: The selector value 1 on `wr_sel`/`rd_sel` addresses the control word and the value 0 addresses the data word. A control read returns all 16 bits last written, reserved bits included. A data read returns the live counter.
- R3: Control bit 7 is the run enable. A control write that takes bit 7 from 0 to 1 loads the counter with the reload word at that clock edge. While bit 7 is 0 the counter holds its value.
- R4: When bit 2 is clear, control bits [1:0] pick the prescale ratio: code 0 is 1, code 1 is 2^PSC1_LOG2, code 2 is 2^PSC2_LOG2 and code 3 is 2^PSC3_LOG2. The defaults give 64, 256 and 1024. After an enabling write, the first increment comes at the ratio-th clock edge after that write, and increments follow every ratio clocks.
- R5: An increment that finds the counter at 0xFFFF is an overflow. The counter then takes the reload word instead of 0x0000.
- R6: Control bit 6 is the interrupt enable. With bit 6 set, `irq[n]` is high for exactly the clock in which channel n overflows. With bit 6 clear, `irq[n]` stays 0.
- R7: Control bit 2 is chained mode. In this mode, channel n (n > 0) ignores its prescaler and advances by one in the same clock that channel n-1 overflows, but only while its own bit 7 is set.
- R8: Chained mode on channel 0 never advances it. The overflow of channel 3 drives nothing further.
- R9: A data write to a running channel changes only its reload word. The live count continues from its current value.
- R10: The prescaler accumulator clears while a channel is disabled. After the channel is enabled again, the first increment comes a full ratio after the enabling write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_sel | input | 1 | Write target: 1 control word, 0 data (reload) word |
| wr_data | input | 16 | Write value |
| rd_ch | input | 2 | Channel addressed by the read |
| rd_sel | input | 1 | Read source: 1 control word, 0 live counter |
| rd_data | output | 16 | Read value, combinational from rd_ch and rd_sel |
| irq | output | 4 | Per-channel overflow interrupt pulses |

## Verification
The bench builds the bank with prescale exponents 2, 3 and 4, which give ratios of 1, 4, 8 and 16. With these ratios, all four ratio codes, several overflows per channel and a two-stage chain fit into a few hundred cycles. The large default ratios are only elaborated. Reload words close to 0xFFFF bring overflow, reload, coincident interrupts on chained channels and the re-enable restart into a short run. A behavioural model compares the interrupt vector and the selected read value on every clock.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
   localparam int CTL_W     = 16;
   localparam int CTL_PSC   = 0;
   localparam int CTL_CHAIN = 2;
   localparam int CTL_IE    = 6;
   localparam int CTL_RUN   = 7;

   typedef enum logic {
      SEL_DATA = 1'b0,
      SEL_CTL  = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PSC1_LOG2 = 6,
   parameter int PSC2_LOG2 = 8,
   parameter int PSC3_LOG2 = 10
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       run_i,
   input  logic [1:0] sel_i,
   output logic       tick_o
);
   localparam int MAX12  = (PSC1_LOG2 > PSC2_LOG2) ? PSC1_LOG2 : PSC2_LOG2;
   localparam int MAXSH  = (MAX12 > PSC3_LOG2) ? MAX12 : PSC3_LOG2;
   localparam int ACC_W  = (MAXSH < 1) ? 1 : MAXSH;

   if (PSC1_LOG2 < 1 || PSC1_LOG2 > 20) begin : g_bad_psc1
      $error("PSC1_LOG2 out of range");
   end
   if (PSC2_LOG2 < 1 || PSC2_LOG2 > 20) begin : g_bad_psc2
      $error("PSC2_LOG2 out of range");
   end
   if (PSC3_LOG2 < 1 || PSC3_LOG2 > 20) begin : g_bad_psc3
      $error("PSC3_LOG2 out of range");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] limit;

   always_comb begin
      case (sel_i)
         2'd1:    limit = ACC_W'((1 << PSC1_LOG2) - 1);
         2'd2:    limit = ACC_W'((1 << PSC2_LOG2) - 1);
         2'd3:    limit = ACC_W'((1 << PSC3_LOG2) - 1);
         default: limit = '0;
      endcase
   end

   assign tick_o = run_i && (acc_q >= limit);

   always_ff @(posedge clk) begin
      if (rst || !run_i) begin
         acc_q <= '0;
      end else if (tick_o) begin
         acc_q <= '0;
      end else begin
         acc_q <= acc_q + 1'b1;
      end
   end

   // R4
   tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (run_i && $past(run_i) && $stable(sel_i) && sel_i != 2'd0 && tick_o) |-> !$past(tick_o));

   // R10
   acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!run_i) |=> !tick_o || !run_i || (sel_i == 2'd0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import timer_bank_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 16,
   parameter int PSC1_LOG2 = 6,
   parameter int PSC2_LOG2 = 8,
   parameter int PSC3_LOG2 = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_ctl_i,
   input  logic              wr_rld_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              chain_i,
   output logic              ovf_o,
   output logic              irq_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [DATA_W-1:0] ctl_o
);
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 1..DATA_W");
   end
   if (DATA_W < CTL_W) begin : g_bad_data
      $error("DATA_W too narrow for control word");
   end

   logic [DATA_W-1:0] ctl_q;
   logic [CNT_W-1:0]  rld_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              run, chained, load_now, pre_tick, advance;

   assign run      = ctl_q[CTL_RUN];
   assign chained  = ctl_q[CTL_CHAIN];
   assign load_now = wr_ctl_i && wdata_i[CTL_RUN] && !run;

   tmr_prescaler #(
      .PSC1_LOG2 (PSC1_LOG2),
      .PSC2_LOG2 (PSC2_LOG2),
      .PSC3_LOG2 (PSC3_LOG2)
   ) i_psc (
      .clk    (clk),
      .rst    (rst),
      .run_i  (run && !chained),
      .sel_i  (ctl_q[CTL_PSC +: 2]),
      .tick_o (pre_tick)
   );

   assign advance = run && (chained ? chain_i : pre_tick);
   assign ovf_o   = advance && (cnt_q == {CNT_W{1'b1}});
   assign irq_o   = ovf_o && ctl_q[CTL_IE];
   assign cnt_o   = cnt_q;
   assign ctl_o   = ctl_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q <= '0;
         rld_q <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_ctl_i) ctl_q <= wdata_i;
         if (wr_rld_i) rld_q <= wdata_i[CNT_W-1:0];
         if (load_now) begin
            cnt_q <= rld_q;
         end else if (advance) begin
            cnt_q <= ovf_o ? rld_q : cnt_q + 1'b1;
         end
      end
   end

   // R3
   load_on_start_chk: assert property (@(posedge clk) disable iff (rst)
      load_now |=> cnt_q == $past(rld_q));

   // R5
   reload_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_o |=> cnt_q == $past(rld_q));

   // R7
   chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (run && chained && !chain_i && !load_now) |=> $stable(cnt_q));

   // R7
   chain_step_chk: assert property (@(posedge clk) disable iff (rst)
      (run && chained && chain_i && !load_now) |=>
         (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(rld_q)));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!run && !load_now) |=> $stable(cnt_q));
endmodule

// File: rtl/timer_bank.sv
module timer_bank
   import timer_bank_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 16,
   parameter int PSC1_LOG2 = 6,
   parameter int PSC2_LOG2 = 8,
   parameter int PSC3_LOG2 = 10,
   localparam int CH_W     = (NUM_CH > 2) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CH_W-1:0]   rd_ch,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_CH-1:0] irq
);
   if (NUM_CH < 2 || NUM_CH != (1 << CH_W)) begin : g_bad_ch
      $error("NUM_CH must be a power of two, at least 2");
   end

   logic [NUM_CH-1:0]             ovf;
   logic [NUM_CH-1:0][DATA_W-1:0] cnt_rd;
   logic [NUM_CH-1:0][DATA_W-1:0] ctl_rd;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic             chain_in;
      logic             sel_me;
      logic [CNT_W-1:0] cnt_w;

      if (g == 0) begin : g_base
         assign chain_in = 1'b0;
      end else begin : g_link
         assign chain_in = ovf[g-1];
      end

      assign sel_me = wr_en && (wr_ch == CH_W'(g));

      tmr_channel #(
         .DATA_W    (DATA_W),
         .CNT_W     (CNT_W),
         .PSC1_LOG2 (PSC1_LOG2),
         .PSC2_LOG2 (PSC2_LOG2),
         .PSC3_LOG2 (PSC3_LOG2)
      ) i_ch (
         .clk      (clk),
         .rst      (rst),
         .wr_ctl_i (sel_me && (wr_sel == SEL_CTL)),
         .wr_rld_i (sel_me && (wr_sel == SEL_DATA)),
         .wdata_i  (wr_data),
         .chain_i  (chain_in),
         .ovf_o    (ovf[g]),
         .irq_o    (irq[g]),
         .cnt_o    (cnt_w),
         .ctl_o    (ctl_rd[g])
      );

      assign cnt_rd[g] = DATA_W'(cnt_w);
   end

   assign rd_data = (rd_sel == SEL_CTL) ? ctl_rd[rd_ch] : cnt_rd[rd_ch];

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (irq == '0));
endmodule

// File: tb/test_timer_bank.sv
`timescale 1ns/1ps
module test_timer_bank;
   localparam int SH1 = 2;
   localparam int SH2 = 3;
   localparam int SH3 = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_ch = '0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_ch = '0;
   logic        rd_sel = 1'b0;
   logic [15:0] rd_data;
   logic [3:0]  irq;

   always #5 clk = ~clk;

   timer_bank #(.PSC1_LOG2(SH1), .PSC2_LOG2(SH2), .PSC3_LOG2(SH3)) i_timer_bank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
   );

   int errors = 0;
   int checks = 0;
   int n_irq0 = 0, n_both01 = 0, n_irq3 = 0;
   string cur_tag = "R1";

   logic [15:0] m_cnt [4];
   logic [15:0] m_rld [4];
   logic [15:0] m_ctl [4];
   int          m_acc [4];
   logic [3:0]  m_tick, m_ov, m_irq;

   function automatic int ratio(logic [1:0] s);
      case (s)
         2'd1:    return 1 << SH1;
         2'd2:    return 1 << SH2;
         2'd3:    return 1 << SH3;
         default: return 1;
      endcase
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_comb();
      for (int n = 0; n < 4; n++) begin
         if (!m_ctl[n][7]) m_tick[n] = 1'b0;
         else if (m_ctl[n][2]) m_tick[n] = (n > 0) ? m_ov[n-1] : 1'b0;
         else m_tick[n] = (m_acc[n] >= ratio(m_ctl[n][1:0]) - 1);
         m_ov[n]  = m_tick[n] && (m_cnt[n] == 16'hFFFF);
         m_irq[n] = m_ov[n] && m_ctl[n][6];
      end
   endtask

   task automatic model_update();
      for (int n = 0; n < 4; n++) begin
         logic wctl, wrl, run;
         run  = m_ctl[n][7];
         wctl = wr_en && wr_sel && (wr_ch == n);
         wrl  = wr_en && !wr_sel && (wr_ch == n);
         if (wctl && wr_data[7] && !run) m_cnt[n] = m_rld[n];
         else if (m_tick[n]) m_cnt[n] = m_ov[n] ? m_rld[n] : m_cnt[n] + 16'd1;
         if (!run || m_ctl[n][2] || m_tick[n]) m_acc[n] = 0;
         else m_acc[n] = m_acc[n] + 1;
         if (wctl) m_ctl[n] = wr_data;
         if (wrl)  m_rld[n] = wr_data;
      end
   endtask

   task automatic step();
      model_comb();
      #1;
      check({cur_tag, " R6 irq"}, {12'd0, irq}, {12'd0, m_irq});
      check({cur_tag, " R2 read"}, rd_data, rd_sel ? m_ctl[rd_ch] : m_cnt[rd_ch]);
      if (irq[0]) n_irq0++;
      if (irq[0] && irq[1]) n_both01++;
      if (irq[3]) n_irq3++;
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic idle(int cyc);
      for (int i = 0; i < cyc; i++) step();
   endtask

   task automatic wr(logic [1:0] ch, logic sel, logic [15:0] d);
      wr_en = 1'b1; wr_ch = ch; wr_sel = sel; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic peek(logic [1:0] ch, logic sel, logic [15:0] exp, string tag);
      rd_ch = ch; rd_sel = sel;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      for (int n = 0; n < 4; n++) begin
         m_cnt[n] = '0; m_rld[n] = '0; m_ctl[n] = '0; m_acc[n] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      for (int n = 0; n < 4; n++) begin
         peek(2'(n), 1'b0, 16'h0000, "R1 counter after reset");
         peek(2'(n), 1'b1, 16'h0000, "R1 control after reset");
      end
      check("R1 irq after reset", {12'd0, irq}, 16'h0000);

      cur_tag = "R5";
      wr(2'd0, 1'b0, 16'hFFF0);
      wr(2'd0, 1'b1, 16'hA8C0);
      peek(2'd0, 1'b1, 16'hA8C0, "R2 control readback");
      peek(2'd0, 1'b0, 16'hFFF0, "R3 load on enable");
      n_irq0 = 0;
      idle(16);
      peek(2'd0, 1'b0, 16'hFFF0, "R5 reload after wrap");
      idle(24);
      check("R6 irq0 pulse count", 16'(n_irq0), 16'd2);

      cur_tag = "R7";
      wr(2'd1, 1'b0, 16'hFFFE);
      wr(2'd1, 1'b1, 16'h00C4);
      rd_ch = 2'd1; rd_sel = 1'b0;
      n_both01 = 0;
      idle(70);
      check("R7 chained irq coincides", 16'(n_both01 > 0), 16'd1);

      cur_tag = "R8";
      wr(2'd0, 1'b1, 16'h0000);
      wr(2'd0, 1'b0, 16'h1234);
      wr(2'd0, 1'b1, 16'h0084);
      rd_ch = 2'd0;
      idle(30);
      peek(2'd0, 1'b0, 16'h1234, "R8 chained channel 0 holds");

      cur_tag = "R4";
      wr(2'd2, 1'b0, 16'hFFFC);
      wr(2'd2, 1'b1, 16'h00C3);
      idle(15);
      peek(2'd2, 1'b0, 16'hFFFC, "R4 no step before ratio");
      idle(1);
      peek(2'd2, 1'b0, 16'hFFFD, "R4 step at ratio");

      cur_tag = "R6";
      wr(2'd3, 1'b0, 16'hFFF8);
      wr(2'd3, 1'b1, 16'h0082);
      rd_ch = 2'd3;
      n_irq3 = 0;
      idle(120);
      check("R6 irq3 masked", 16'(n_irq3), 16'd0);

      cur_tag = "R9";
      rd_ch = 2'd2;
      idle(5);
      wr(2'd2, 1'b0, 16'h8000);
      idle(40);

      cur_tag = "R10";
      idle(7);
      wr(2'd2, 1'b1, 16'h0043);
      idle(3);
      wr(2'd2, 1'b1, 16'h00C3);
      idle(15);
      peek(2'd2, 1'b0, 16'h8000, "R10 restart full period");
      idle(1);
      peek(2'd2, 1'b0, 16'h8001, "R10 first step after restart");
      idle(20);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule